// File: doc/BRIEF.md
# Differential BPSK Sine Carrier Modulator

The block produces a sampled sine carrier and keys it with differential binary phase shift keying. A 32-bit phase accumulator advances by a programmable increment on every clock. Its top bits address a table that holds one full sine period, and that table is computed while the design elaborates. For a 1 MHz carrier from an 80 MHz clock, the increment is round(1e6 * 2^32 / 80e6) = 53687091. This gives roughly 80 samples per carrier period.

The serial data input is synchronised to the clock. Every change of its level, upward or downward, toggles a phase inversion flag. While the flag is set, the table address is offset by half a period, which turns the carrier through 180 degrees without a break in the sample stream. The carrier phase therefore encodes changes in the data, not its level.

Two outputs are provided. The first is a signed 16-bit sample word for an external DAC. The second is a single-bit stream from a first-order sigma-delta converter running at the clock rate. That stream needs only a resistor and a capacitor outside the chip to recover the analogue carrier.

Top module: `dbpsk_sine_mod`

## Requirements
- R1: While rst_ni is low, sample_o is 0 and sd_o is 0. The phase, the inversion flag, the synchroniser and the converter accumulator are all cleared.
- R2: The internal ACC_W-bit phase advances by phase_inc_i on every rising clock edge, wrapping modulo 2^ACC_W. A new increment affects the phase from the next edge onward.
- R3: The table index n is the top ADDR_W bits of the phase, XOR-ed in its most significant bit with the inversion flag. After each edge, sample_o holds round((2^(SAMPLE_W-1)-1) * sin(2*pi*n/2^ADDR_W)), with n taken from the phase and flag as they stood before that edge.
- R4: sample_o never takes the most negative code -2^(SAMPLE_W-1).
- R5: A level change of data_i, in either direction, that is first sampled at edge e toggles the inversion flag at edge e+2. The inverted half-period offset then shows in sample_o from edge e+3 onward.
- R6: A data_i level held steady, whether high or low, never toggles the inversion flag. After an even number of transitions, the carrier is back in its original phase.
- R7: sd_o is the registered carry of a (SAMPLE_W+1)-bit accumulator. On each edge, the accumulator adds the offset-binary form of sample_o (sign bit inverted) to its low SAMPLE_W bits. Over any window, the count of ones times 2^SAMPLE_W differs from the summed offset codes by at most 2 * 2^SAMPLE_W.
- R8: With sample_o held at 0 (offset code 2^(SAMPLE_W-1)), sd_o alternates between 0 and 1 on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial data, asynchronous to the clock |
| phase_inc_i | input | ACC_W | Phase increment per clock |
| sample_o | output | SAMPLE_W | Signed carrier sample for an external DAC |
| sd_o | output | 1 | First-order sigma-delta bit stream |

## Verification
A data transition can land in the same cycle as a table-address wrap. The bench provokes this by stepping through the whole table one entry per clock while toggling data_i at an interval that is co-prime to the table depth. Each transition therefore strikes a different address, including index 0 and the half-period point. Every cycle, the sample word is compared against an arithmetic sine computed from the bench's own phase count and its delayed record of the data.

The converter output is judged alongside the changing sample word. Two figures are summed over a long window: the offset codes fed to the converter and the ones it emits. These must agree within the bound of R7, and a mid-scale input must give a strict alternation.

// File: rtl/dbpsk_pkg.sv
package dbpsk_pkg;
  localparam real TWO_PI = 6.283185307179586;

  // rounded full-scale sine code for table index idx of depth entries
  function automatic int sine_code(int idx, int depth, int width);
    real amp;
    amp = real'((1 << (width - 1)) - 1);
    return int'(amp * $sin(TWO_PI * real'(idx) / real'(depth)));
  endfunction
endpackage

// File: rtl/dbpsk_edge_sync.sv
module dbpsk_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic edge_o,
  output logic inv_o
);
  logic meta_q, sync_q, prev_q, inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= data_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_o = sync_q ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     inv_q <= 1'b0;
    else if (edge_o) inv_q <= ~inv_q;
  end

  assign inv_o = inv_q;
endmodule

// File: rtl/dbpsk_phase_acc.sv
module dbpsk_phase_acc #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ACC_W-1:0]  inc_i,
  input  logic              inv_i,
  output logic [ACC_W-1:0]  phase_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] HALF = {1'b1, {(ADDR_W-1){1'b0}}};

  logic [ACC_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + inc_i;
  end

  // 180 degree shift: half-period offset on the address
  assign addr_o  = phase_q[ACC_W-1 -: ADDR_W] ^ (inv_i ? HALF : '0);
  assign phase_o = phase_q;
endmodule

// File: rtl/dbpsk_sine_rom.sv
module dbpsk_sine_rom #(
  parameter int ADDR_W   = 10,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic signed [SAMPLE_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    localparam int CODE = dbpsk_pkg::sine_code(i, DEPTH, SAMPLE_W);
    assign tbl[i] = SAMPLE_W'(CODE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_o <= '0;
    else         sample_o <= tbl[addr_i];
  end
endmodule

// File: rtl/dbpsk_sd_dac.sv
module dbpsk_sd_dac #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       bit_o
);
  logic [SAMPLE_W-1:0] offset;
  logic [SAMPLE_W:0]   acc_q;

  assign offset = {~sample_i[SAMPLE_W-1], sample_i[SAMPLE_W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= {1'b0, acc_q[SAMPLE_W-1:0]} + {1'b0, offset};
  end

  assign bit_o = acc_q[SAMPLE_W];
endmodule

// File: rtl/dbpsk_sine_mod.sv
module dbpsk_sine_mod #(
  parameter int ACC_W    = 32,
  parameter int ADDR_W   = 10,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       data_i,
  input  logic [ACC_W-1:0]           phase_inc_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       sd_o
);
  logic              edge_w;
  logic              inv_w;
  logic [ACC_W-1:0]  phase_w;
  logic [ADDR_W-1:0] addr_w;

  dbpsk_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .edge_o (edge_w),
    .inv_o  (inv_w)
  );

  dbpsk_phase_acc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (phase_inc_i),
    .inv_i   (inv_w),
    .phase_o (phase_w),
    .addr_o  (addr_w)
  );

  dbpsk_sine_rom #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_rom (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_w),
    .sample_o (sample_o)
  );

  dbpsk_sd_dac #(.SAMPLE_W(SAMPLE_W)) u_sd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_o),
    .bit_o    (sd_o)
  );
endmodule

// File: rtl/dbpsk_sine_mod_chk.sv
module dbpsk_sine_mod_chk #(
  parameter int ACC_W    = 32,
  parameter int SAMPLE_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ACC_W-1:0]           phase_inc_i,
  input logic [ACC_W-1:0]           phase_w,
  input logic                       edge_w,
  input logic                       inv_w,
  input logic signed [SAMPLE_W-1:0] sample_o,
  input logic                       sd_o
);
  localparam logic [SAMPLE_W-1:0] MIN_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age_q <= '0;
    else if (age_q != 3) age_q <= age_q + 2'd1;
  end

  // R2
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_w == $past(phase_w) + $past(phase_inc_i));

  // R4
  no_min_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != MIN_CODE);

  // R5
  inv_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_w != $past(inv_w)) |-> $past(edge_w));

  // R6
  inv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(edge_w) |-> $stable(inv_w));

  // R8
  sd_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3 && $past(sample_o) == 0 && $past(sample_o, 2) == 0) |-> (sd_o != $past(sd_o)));
endmodule

bind dbpsk_sine_mod dbpsk_sine_mod_chk #(.ACC_W(ACC_W), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_inc_i (phase_inc_i),
  .phase_w     (phase_w),
  .edge_w      (edge_w),
  .inv_w       (inv_w),
  .sample_o    (sample_o),
  .sd_o        (sd_o)
);

// File: tb/dbpsk_sine_mod_test.sv
`timescale 1ns/1ps
module dbpsk_sine_mod_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  AW  = 6;
  localparam int  N   = 1 << AW;
  localparam int  SW  = 16;
  localparam real AMP = 32767.0;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            data;
  logic [31:0]     inc;
  logic signed [SW-1:0] sample;
  logic            sd;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbpsk_sine_mod #(.ACC_W(32), .ADDR_W(AW), .SAMPLE_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .phase_inc_i(inc),
    .sample_o(sample), .sd_o(sd)
  );

  // arithmetic expectation: phase count, delayed data record, sine value
  logic [31:0] ph_m;
  logic [2:0]  dh_m;
  logic        inv_m;
  int          exp_s;

  function automatic int sine_of(int n);
    return int'(AMP * $sin(2.0 * 3.141592653589793 * real'(n) / real'(N)));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_m <= 0; dh_m <= 0; inv_m <= 0; exp_s <= 0;
    end else begin
      exp_s <= sine_of((int'(ph_m >> (32 - AW)) + (inv_m ? N/2 : 0)) % N);
      ph_m  <= ph_m + inc;
      dh_m  <= {dh_m[1:0], data};
      if (dh_m[1] ^ dh_m[2]) inv_m <= ~inv_m;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // run n cycles comparing sample each cycle; toggle data every tog cycles (0 = never)
  task automatic run(int n, int tog, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(int'(sample) == exp_s, tag, sample, exp_s);
      chk(sample != -32768, "R4", sample, -32767);
      if (tog != 0 && (k % tog) == tog - 1) data = ~data;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sample == 0, "R1", sample, 0);
    chk(sd == 1'b0, "R1", sd, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    data  = 1'b0;
    inc   = 32'd0;
    do_reset();

    // one table entry per clock: every index visited, transitions at co-prime spacing
    inc = 32'h1 << (32 - AW);
    run(3 * N, 0, "R3");
    run(40 * N, 23, "R5");

    // held high and held low: carrier must follow the undisturbed sweep
    data = 1'b1;
    run(2 * N, 0, "R6");
    data = 1'b0;
    run(2 * N, 0, "R6");
    begin : r6_even
      logic signed [SW-1:0] s_ref;
      @(negedge clk);
      s_ref = sample;
      data = 1'b1; repeat (10) @(negedge clk);
      data = 1'b0; repeat (N - 10) @(negedge clk);
      chk(sample == s_ref, "R6", sample, s_ref);
    end

    // carrier near 1 MHz at 80 MHz clock, then a negative (wrapping) increment
    inc = 32'd53687091;
    run(1500, 97, "R2");
    inc = 32'hFFFF_FFFF - 32'd40000000;
    run(800, 61, "R2");

    // zero increment after reset: mid-scale input alternates
    inc = 32'd0;
    data = 1'b0;
    do_reset();
    repeat (5) @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      logic prev;
      prev = sd;
      @(negedge clk);
      chk(sd != prev, "R8", sd, !prev);
    end

    // bit density against summed offset codes
    inc = 32'd53687091;
    begin : r7_density
      longint sum_off;
      longint ones;
      longint diff;
      sum_off = 0; ones = 0;
      for (int k = 0; k < 8000; k++) begin
        @(negedge clk);
        ones += sd;
        sum_off += longint'(sample) + 32768;
        if (k % 211 == 0) data = ~data;
      end
      diff = ones * 65536 - sum_off;
      if (diff < 0) diff = -diff;
      chk(diff <= 2 * 65536, "R7", ones * 65536, sum_off);
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule